// File: doc/BRIEF.md
# Subroutine call/return sequencer

This block carries out the two micro-coded subroutine instructions of a small 8-bit processor core: a standard call and a standard return. It executes them against an external file of sixteen 16-bit registers and a byte-wide memory. The return address is held in a general register chosen by the instruction, called the link register. The memory stack only stores the previous contents of that link register. Three register indices come with each command: the link index (the low nibble of the instruction's second byte), the program-counter index and the stack-pointer index.

For a call, the old link value is pushed onto the stack with its low byte first, at the stack pointer, and its high byte one address below. The stack pointer then drops by two. The program counter is copied into the link register, the two inline bytes it points to become the new program counter, and the link register is moved past those bytes. A return undoes this. The link register goes back into the program counter, the saved link value is read back from the two bytes above the stack pointer, and the stack pointer rises by two. An internal 8-bit temporary is overwritten along the way.

The block has no data stream. It has a plain start/busy/done control handshake, a single-strobe memory port with no back-pressure, and a register file port with one combinational read and one write per cycle. A start is taken only while the block is idle. The memory must return read data on the cycle after a read strobe.

Top module: `callret_seq`

## Requirements
- R1: A start is accepted only while busy is low and op_kind is 4'h8 (call) or 4'h9 (return). A start with any other op_kind leaves busy low and changes no register or memory byte.
- R2: A call writes the low byte of the link register to memory at the stack pointer and its high byte at stack pointer minus one, then lowers the stack pointer by two.
- R3: After the push, a call copies the program counter into the link register. It loads the program counter with the byte at that address as the high half and the byte at the next address as the low half, then adds two to the link register.
- R4: A return copies the link register into the program counter. It loads the link register with the byte at stack pointer plus one as the high half and the byte at stack pointer plus two as the low half, then adds two to the stack pointer.
- R5: When two or three of the indices are equal, the final registers and memory equal the result of applying the steps of R2 and R3, or of R4, strictly one after another in the order listed.
- R6: done is high for exactly one cycle. Counting the clock edge that accepts the start as edge 1, done is high after edge 10 for a call and after edge 8 for a return. busy is low in the cycle after done.
- R7: A start raised while busy is high is ignored and does not change the running operation's result.
- R8: mem_rd and mem_wr are never high in the same cycle.
- R9: All address and register arithmetic wraps modulo 2^16.
- R10: After reset, busy, done, mem_rd, mem_wr and rf_we are low.
- R11: While busy is low, mem_rd, mem_wr and rf_we stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command pulse, sampled while idle |
| op_kind | input | 4 | High nibble of the second instruction byte: 8 call, 9 return |
| link_sel | input | IDX_W | Link register index |
| pc_sel | input | IDX_W | Program-counter register index |
| sp_sel | input | IDX_W | Stack-pointer register index |
| busy | output | 1 | High from acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | IDX_W | Register file read index |
| rf_rdata | input | ADDR_W | Register file read data, combinational from rf_raddr |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | IDX_W | Register file write index |
| rf_wdata | output | ADDR_W | Register file write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | ADDR_W/2 | Memory write data |
| mem_rdata | input | ADDR_W/2 | Memory read data, valid the cycle after mem_rd |

## Verification
The assertions check several rules on every cycle: the two memory strobes are exclusive, everything is silent while idle, busy holds until done, done is a single pulse, and each operation takes its exact length. Rejection of a bad opcode is also checked each cycle. The resulting register and memory contents can only be judged by the bench's scenarios. They compare the outcome against a sequential reference, including runs with aliased indices, pointer wrap across 0xFFFF/0x0000, and a second start injected mid-operation.

// File: rtl/callret_pkg.sv
package callret_pkg;
  localparam logic [3:0] OPK_CALL = 4'h8;
  localparam logic [3:0] OPK_RET  = 4'h9;

  typedef enum logic [4:0] {
    ST_IDLE,
    C_RDX, C_RDN, C_WLO, C_WHI, C_SETX, C_LINK, C_HI, C_SETP, C_ADV,
    R_RDN, R_SETP, R_RDX, R_RHI, R_RLO, R_SETN, R_ADVX,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/callret_fsm.sv
module callret_fsm
  import callret_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       op_kind,
  input  logic [IDX_W-1:0] link_sel,
  input  logic [IDX_W-1:0] pc_sel,
  input  logic [IDX_W-1:0] sp_sel,
  output seq_state_e       state,
  output logic [IDX_W-1:0] n_q,
  output logic [IDX_W-1:0] p_q,
  output logic [IDX_W-1:0] x_q
);
  seq_state_e nxt;
  logic       take;

  assign take = (state == ST_IDLE) && start &&
                ((op_kind == OPK_CALL) || (op_kind == OPK_RET));

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (take) nxt = (op_kind == OPK_CALL) ? C_RDX : R_RDN;
      C_RDX:   nxt = C_RDN;
      C_RDN:   nxt = C_WLO;
      C_WLO:   nxt = C_WHI;
      C_WHI:   nxt = C_SETX;
      C_SETX:  nxt = C_LINK;
      C_LINK:  nxt = C_HI;
      C_HI:    nxt = C_SETP;
      C_SETP:  nxt = C_ADV;
      C_ADV:   nxt = ST_DONE;
      R_RDN:   nxt = R_SETP;
      R_SETP:  nxt = R_RDX;
      R_RDX:   nxt = R_RHI;
      R_RHI:   nxt = R_RLO;
      R_RLO:   nxt = R_SETN;
      R_SETN:  nxt = R_ADVX;
      R_ADVX:  nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      n_q   <= '0;
      p_q   <= '0;
      x_q   <= '0;
    end else begin
      state <= nxt;
      if (take) begin
        n_q <= link_sel;
        p_q <= pc_sel;
        x_q <= sp_sel;
      end
    end
  end
endmodule

// File: rtl/callret_dp.sv
module callret_dp
  import callret_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic [IDX_W-1:0]  n_q,
  input  logic [IDX_W-1:0]  p_q,
  input  logic [IDX_W-1:0]  x_q,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [ADDR_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [ADDR_W-1:0] rf_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W/2-1:0] mem_wdata,
  input  logic [ADDR_W/2-1:0] mem_rdata
);
  localparam int BYTE_W = ADDR_W / 2;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] sp_q, link_q, pc_q;
  logic [BYTE_W-1:0] tmp_q;

  always_comb begin
    rf_raddr  = '0;
    rf_we     = 1'b0;
    rf_waddr  = '0;
    rf_wdata  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      C_RDX: rf_raddr = x_q;
      C_RDN: rf_raddr = n_q;
      C_WLO: begin
        mem_wr    = 1'b1;
        mem_addr  = sp_q;
        mem_wdata = link_q[BYTE_W-1:0];
      end
      C_WHI: begin
        mem_wr    = 1'b1;
        mem_addr  = sp_q - ONE;
        mem_wdata = link_q[ADDR_W-1:BYTE_W];
      end
      C_SETX: begin
        rf_we    = 1'b1;
        rf_waddr = x_q;
        rf_wdata = sp_q - TWO;
      end
      C_LINK: begin
        rf_raddr = p_q;
        rf_we    = 1'b1;
        rf_waddr = n_q;
        rf_wdata = rf_rdata;
        mem_rd   = 1'b1;
        mem_addr = rf_rdata;
      end
      C_HI: begin
        mem_rd   = 1'b1;
        mem_addr = pc_q + ONE;
      end
      C_SETP: begin
        rf_we    = 1'b1;
        rf_waddr = p_q;
        rf_wdata = {tmp_q, mem_rdata};
      end
      C_ADV, R_ADVX: begin
        rf_raddr = (state == C_ADV) ? n_q : x_q;
        rf_we    = 1'b1;
        rf_waddr = rf_raddr;
        rf_wdata = rf_rdata + TWO;
      end
      R_RDN: rf_raddr = n_q;
      R_SETP: begin
        rf_we    = 1'b1;
        rf_waddr = p_q;
        rf_wdata = link_q;
      end
      R_RDX: rf_raddr = x_q;
      R_RHI: begin
        mem_rd   = 1'b1;
        mem_addr = sp_q + ONE;
      end
      R_RLO: begin
        mem_rd   = 1'b1;
        mem_addr = sp_q + TWO;
      end
      R_SETN: begin
        rf_we    = 1'b1;
        rf_waddr = n_q;
        rf_wdata = {tmp_q, mem_rdata};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= '0;
      link_q <= '0;
      pc_q   <= '0;
      tmp_q  <= '0;
    end else begin
      case (state)
        C_RDX, R_RDX: sp_q   <= rf_rdata;
        C_RDN, R_RDN: link_q <= rf_rdata;
        C_LINK:       pc_q   <= rf_rdata;
        C_HI, R_RLO:  tmp_q  <= mem_rdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          op_kind,
  input  logic [IDX_W-1:0]    link_sel,
  input  logic [IDX_W-1:0]    pc_sel,
  input  logic [IDX_W-1:0]    sp_sel,
  output logic                busy,
  output logic                done,
  output logic [IDX_W-1:0]    rf_raddr,
  input  logic [ADDR_W-1:0]   rf_rdata,
  output logic                rf_we,
  output logic [IDX_W-1:0]    rf_waddr,
  output logic [ADDR_W-1:0]   rf_wdata,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [ADDR_W/2-1:0] mem_wdata,
  input  logic [ADDR_W/2-1:0] mem_rdata
);
  seq_state_e       state;
  logic [IDX_W-1:0] n_q, p_q, x_q;

  callret_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
    .link_sel(link_sel), .pc_sel(pc_sel), .sp_sel(sp_sel),
    .state(state), .n_q(n_q), .p_q(p_q), .x_q(x_q)
  );

  callret_dp #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .state(state),
    .n_q(n_q), .p_q(p_q), .x_q(x_q),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/callret_seq_chk.sv
module callret_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [3:0] op_kind,
  input logic       busy,
  input logic       done,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       rf_we
);
  logic [4:0] span_q;
  logic       was_call_q;
  logic       kind_ok;

  assign kind_ok = (op_kind == 4'h8) || (op_kind == 4'h9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q     <= '0;
      was_call_q <= 1'b0;
    end else if (start && !busy && kind_ok) begin
      span_q     <= 5'd1;
      was_call_q <= (op_kind == 4'h8);
    end else if (busy && span_q != 5'd31) begin
      span_q <= span_q + 5'd1;
    end
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr && !rf_we));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R6
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (span_q == (was_call_q ? 5'd10 : 5'd8)));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R1
  bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !kind_ok) |=> !busy);
endmodule

bind callret_seq callret_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
  .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr), .rf_we(rf_we)
);

// File: tb/tb_callret_seq.sv
module tb_callret_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op_kind = '0;
  logic [3:0]  link_sel = '0, pc_sel = '0, sp_sel = '0;
  logic        busy, done;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata, mem_addr;
  logic        rf_we, mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int n_checks = 0;
  int n_fail = 0;
  int both_strobe = 0;
  int idle_act = 0;

  logic [15:0] hw_rf [16];
  logic [7:0]  hw_mem [256];
  logic [15:0] init_rf [16];
  logic [7:0]  init_mem [256];
  logic [15:0] ref_rf [16];
  logic [7:0]  ref_mem [256];
  logic        do_load = 1'b0;

  always #4 clk = ~clk;

  callret_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
    .link_sel(link_sel), .pc_sel(pc_sel), .sp_sel(sp_sel),
    .busy(busy), .done(done),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign rf_rdata = hw_rf[rf_raddr];

  always @(posedge clk) begin
    if (do_load) begin
      for (int i = 0; i < 16; i++) hw_rf[i] <= init_rf[i];
      for (int i = 0; i < 256; i++) hw_mem[i] <= init_mem[i];
    end else begin
      if (rf_we) hw_rf[rf_waddr] <= rf_wdata;
      if (mem_wr) hw_mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= hw_mem[mem_addr[7:0]];
    end
    if (rst_n && mem_rd && mem_wr) both_strobe++;
    if (rst_n && !busy && (mem_rd || mem_wr || rf_we)) idle_act++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic randomize_init();
    for (int i = 0; i < 16; i++) init_rf[i] = 16'($urandom);
    for (int i = 0; i < 256; i++) init_mem[i] = 8'($urandom);
  endtask

  task automatic commit();
    @(negedge clk); do_load = 1'b1;
    @(negedge clk); do_load = 1'b0;
    for (int i = 0; i < 16; i++) ref_rf[i] = init_rf[i];
    for (int i = 0; i < 256; i++) ref_mem[i] = init_mem[i];
  endtask

  task automatic ref_call(input int n, input int p, input int x);
    logic [15:0] sp, lk, a;
    logic [7:0] hi, lo;
    sp = ref_rf[x]; lk = ref_rf[n];
    ref_mem[sp[7:0]] = lk[7:0];
    a = sp - 16'd1; ref_mem[a[7:0]] = lk[15:8];
    ref_rf[x] = sp - 16'd2;
    ref_rf[n] = ref_rf[p];
    a = ref_rf[n]; hi = ref_mem[a[7:0]];
    a = a + 16'd1; lo = ref_mem[a[7:0]];
    ref_rf[p] = {hi, lo};
    ref_rf[n] = ref_rf[n] + 16'd2;
  endtask

  task automatic ref_ret(input int n, input int p, input int x);
    logic [15:0] a;
    logic [7:0] hi, lo;
    ref_rf[p] = ref_rf[n];
    a = ref_rf[x] + 16'd1; hi = ref_mem[a[7:0]];
    a = ref_rf[x] + 16'd2; lo = ref_mem[a[7:0]];
    ref_rf[n] = {hi, lo};
    ref_rf[x] = ref_rf[x] + 16'd2;
  endtask

  task automatic compare_state(input string req);
    int bad_r = 0, bad_m = 0, fr = 0, fm = 0;
    for (int i = 0; i < 16; i++)
      if (hw_rf[i] !== ref_rf[i]) begin if (bad_r == 0) fr = i; bad_r++; end
    for (int i = 0; i < 256; i++)
      if (hw_mem[i] !== ref_mem[i]) begin if (bad_m == 0) fm = i; bad_m++; end
    chk(bad_r == 0, req, $sformatf("register %0d", fr), hw_rf[fr], ref_rf[fr]);
    chk(bad_m == 0, req, $sformatf("memory byte %0h", fm), hw_mem[fm], ref_mem[fm]);
  endtask

  task automatic run_op(input bit is_call, input int n, input int p, input int x,
                        input bit poke, input string req);
    int cyc = 0;
    if (is_call) ref_call(n, p, x); else ref_ret(n, p, x);
    @(negedge clk);
    start = 1'b1; op_kind = is_call ? 4'h8 : 4'h9;
    link_sel = 4'(n); pc_sel = 4'(p); sp_sel = 4'(x);
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == 1) start = 1'b0;
      if (poke && cyc == 3) begin
        start = 1'b1; op_kind = is_call ? 4'h9 : 4'h8;
        link_sel = 4'(x); pc_sel = 4'(n); sp_sel = 4'(p);
      end
      if (poke && cyc == 4) start = 1'b0;
    end while (!done && cyc < 40);
    chk(cyc == (is_call ? 10 : 8), "R6", "edges to done", cyc, is_call ? 10 : 8);
    @(negedge clk);
    chk(!done && !busy, "R6", "done/busy after pulse", {done, busy}, 0);
    compare_state(req);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_rd && !mem_wr && !rf_we, "R10", "outputs after reset",
        {busy, done, mem_rd, mem_wr, rf_we}, 0);
  endtask

  task automatic t_call_basic();
    randomize_init(); init_rf[2] = 16'h2040; init_rf[1] = 16'h1080; commit();
    run_op(1'b1, 3, 1, 2, 1'b0, "R2");
    chk(hw_rf[2] == 16'h203e, "R2", "stack pointer", hw_rf[2], 16'h203e);
    chk(hw_rf[3] == 16'h1082, "R3", "link after call", hw_rf[3], 16'h1082);
  endtask

  task automatic t_ret_basic();
    randomize_init(); init_rf[2] = 16'h3010; init_rf[3] = 16'h4455;
    init_mem[8'h11] = 8'hab; init_mem[8'h12] = 8'hcd; commit();
    run_op(1'b0, 3, 1, 2, 1'b0, "R4");
    chk(hw_rf[1] == 16'h4455 && hw_rf[3] == 16'habcd && hw_rf[2] == 16'h3012,
        "R4", "pc/link/sp after return", hw_rf[3], 16'habcd);
  endtask

  task automatic t_alias();
    randomize_init(); commit(); run_op(1'b1, 5, 1, 5, 1'b0, "R5");
    randomize_init(); commit(); run_op(1'b1, 4, 4, 2, 1'b0, "R5");
    randomize_init(); commit(); run_op(1'b1, 6, 6, 6, 1'b0, "R5");
    randomize_init(); commit(); run_op(1'b0, 7, 2, 2, 1'b0, "R5");
    randomize_init(); commit(); run_op(1'b0, 7, 1, 7, 1'b0, "R5");
  endtask

  task automatic t_wrap();
    randomize_init(); init_rf[9] = 16'h0000; init_rf[8] = 16'hffff; commit();
    run_op(1'b1, 10, 8, 9, 1'b0, "R9");
    chk(hw_rf[9] == 16'hfffe, "R9", "sp wrap down", hw_rf[9], 16'hfffe);
    chk(hw_rf[10] == 16'h0001, "R9", "link wrap up", hw_rf[10], 16'h0001);
    randomize_init(); init_rf[9] = 16'hffff; commit();
    run_op(1'b0, 10, 8, 9, 1'b0, "R9");
    chk(hw_rf[9] == 16'h0001, "R9", "sp wrap up", hw_rf[9], 16'h0001);
  endtask

  task automatic t_bad_kind();
    int seen = 0;
    randomize_init(); commit();
    @(negedge clk);
    start = 1'b1; op_kind = 4'ha; link_sel = 4'd1; pc_sel = 4'd2; sp_sel = 4'd3;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (busy) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R1", "busy after bad kind", seen, 0);
    compare_state("R1");
  endtask

  task automatic t_busy_start();
    randomize_init(); commit(); run_op(1'b1, 3, 12, 13, 1'b1, "R7");
    randomize_init(); commit(); run_op(1'b0, 3, 12, 13, 1'b1, "R7");
  endtask

  task automatic t_random();
    for (int k = 0; k < 24; k++) begin
      randomize_init(); commit();
      run_op(k[0], int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
             int'($urandom_range(0, 15)), 1'b0, "R5");
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL R6 watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) init_rf[i] = '0;
    for (int i = 0; i < 256; i++) init_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_call_basic();
    t_ret_basic();
    t_alias();
    t_wrap();
    t_bad_kind();
    t_busy_start();
    t_random();
    chk(both_strobe == 0, "R8", "cycles with both strobes", both_strobe, 0);
    chk(idle_act == 0, "R11", "activity while idle", idle_act, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule